// File: doc/BRIEF.md
# Per-Thread Squash Arbiter

This block decides, for every hardware thread of a multithreaded out-of-order core, whether a pipeline flush happens in the current cycle and where it starts. Three sources can ask for a flush. The first is a trap, which takes effect only after a fixed trap latency. The second is a context-write request, which flushes the whole thread. The third is an execute-stage request that names a sequence number and carries redirect information.

An execute-stage request is filtered by age. It is honoured only when it is no younger than the youngest instruction the thread currently holds, and only when no trap is waiting to take effect on that thread.

When a flush is taken, the block does two things on the next clock edge:
- It issues a one-cycle command, with a squash point, to the external reorder buffer.
- It sends a registered broadcast record to the earlier stages. The record holds a squash pulse, the done sequence number, the mispredict and taken flags, and the two redirect PCs.

The thread then stays in a squashing state until the reorder buffer reports that it has finished. The block also tells the earlier stages when a thread's buffer may be treated as empty.

All requests are single-cycle pulses sampled on the rising clock edge. The block always accepts them, so no ready or back-pressure signal exists: a request that the rules reject is dropped.

Top module: `squash_arbiter`

## Requirements
- R1: A trap request on a thread that has no trap in flight raises `trap_inflight` on the next edge. The whole-thread squash it causes appears on the outputs exactly TRAP_LAT+1 edges after the request edge, and `trap_inflight` falls on that same edge.
- R2: When a trap is due and a context-write squash is pending on the same thread, the trap squash is issued first. The context-write squash is issued on the following edge.
- R3: A whole-thread squash (trap or context-write) uses the head sequence number minus one as its squash point, or zero when the thread's buffer is empty. It drives that point as both the done number and the buffer squash number, clears the mispredict and taken flags, and takes the redirect PCs from the thread's saved PC and next PC. It resets the youngest-held sequence number to zero.
- R4: An execute-stage request is accepted only when the thread has no trap in flight and its sequence number is less than or equal to the youngest-held sequence number (equal is accepted). A rejected request produces no squash pulse. The youngest-held number is loaded from the allocation port when no squash is taken.
- R5: For an accepted execute-stage request, the squash point is the requested number minus one when the include-self flag is 1, and the requested number itself otherwise. The squash point becomes the done number and the new youngest-held number. The mispredict flag, taken flag and both PCs are copied from the request.
- R6: With DELAY_SLOT=1, an accepted request that has the mispredict flag at 1 and the keep-slot flag at 1 sends the buffer a squash number one above the done number. In every other case the buffer number equals the done number.
- R7: After a squash, `bc_squashing` for the thread is 1 on every cycle until an edge on which `rob_done_sq` is 1. On that edge it returns to 0.
- R8: `empty_ind` pulses for a thread only when all of the following hold: an indication is owed (after reset or after any squash), the thread's buffer is empty, `stores_pending` is 0, and the thread's `store_committed` is 0.
- R9: `bc_squash`, `rob_sq_cmd` and `empty_ind` are registered pulses that last one cycle. `rob_sq_cmd` is high exactly when `bc_squash` is high. After reset all pulses, `bc_squashing` and `trap_inflight` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | NT | Per-thread trap request pulse |
| ctx_sq_req | input | NT | Per-thread context-write squash pulse |
| ex_sq_valid | input | NT | Per-thread execute-stage squash request |
| ex_sq_seq | input | NT*SEQ_W | Requested sequence number |
| ex_incl_self | input | NT | Include the named instruction in the squash |
| ex_mispred | input | NT | Request comes from a branch mispredict |
| ex_taken | input | NT | Branch taken flag |
| ex_keep_slot | input | NT | Keep the delay slot (mispredict only) |
| ex_pc | input | NT*PC_W | Redirect PC |
| ex_npc | input | NT*PC_W | Redirect next PC |
| alloc_valid | input | NT | New youngest instruction allocated |
| alloc_seq | input | NT*SEQ_W | Sequence number of that instruction |
| rob_empty | input | NT | Thread's reorder buffer is empty |
| rob_head_seq | input | NT*SEQ_W | Sequence number at the buffer head |
| rob_done_sq | input | NT | Buffer has finished squashing |
| stores_pending | input | 1 | Stores still waiting for writeback |
| store_committed | input | NT | A store committed this cycle |
| saved_pc | input | NT*PC_W | Thread's saved PC |
| saved_npc | input | NT*PC_W | Thread's saved next PC |
| bc_squash | output | NT | Broadcast squash pulse |
| bc_squashing | output | NT | Squash in progress |
| bc_done_seq | output | NT*SEQ_W | Broadcast done sequence number |
| bc_mispred | output | NT | Broadcast mispredict flag |
| bc_taken | output | NT | Broadcast taken flag |
| bc_pc | output | NT*PC_W | Broadcast redirect PC |
| bc_npc | output | NT*PC_W | Broadcast redirect next PC |
| rob_sq_cmd | output | NT | Squash command to the buffer |
| rob_sq_seq | output | NT*SEQ_W | Buffer squash sequence number |
| empty_ind | output | NT | Empty-buffer indication pulse |
| trap_inflight | output | NT | Trap waiting to take effect |

## Verification
The hardest situation to reach is a trap squash and a context-write squash that are due on the same thread in the same cycle. A context-write request that arrives earlier is simply served at once. The stimulus therefore issues the context-write request on exactly the edge where the trap latency expires. It also changes the buffer head between the two issue edges, so that the order in which the broadcast records arrive shows which squash won. A second difficult case is an execute request that arrives while a trap is counting down. The bench sends one in the middle of the latency window and checks that no pulse results. It then confirms that the youngest-held number was reset to zero: a request for sequence 1 is rejected and a request for sequence 0 is accepted.

// File: rtl/squash_pkg.sv
package squash_pkg;

  typedef enum logic {
    TH_RUN    = 1'b0,
    TH_SQUASH = 1'b1
  } thr_state_e;

endpackage

// File: rtl/squash_trap_timer.sv
module squash_trap_timer #(
  parameter int TRAP_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic inflight,
  output logic due
);
  localparam int CNT_W = $clog2(TRAP_LAT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      due      <= 1'b0;
      cnt_q    <= '0;
    end else if (clear) begin
      inflight <= 1'b0;
      due      <= 1'b0;
    end else if (start && !inflight) begin
      inflight <= 1'b1;
      cnt_q    <= CNT_W'(TRAP_LAT - 1);
    end else if (inflight && !due) begin
      if (cnt_q == '0) due <= 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_DUE_IMPLIES_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    due |-> inflight); // R1

endmodule

// File: rtl/squash_thread_ctrl.sv
module squash_thread_ctrl
  import squash_pkg::*;
#(
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int TRAP_LAT   = 4,
  parameter bit DELAY_SLOT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic             ctx_req,
  input  logic             ex_valid,
  input  logic [SEQ_W-1:0] ex_seq,
  input  logic             ex_incl,
  input  logic             ex_mis,
  input  logic             ex_tak,
  input  logic             ex_keep,
  input  logic [PC_W-1:0]  ex_pc,
  input  logic [PC_W-1:0]  ex_npc,
  input  logic             alloc_valid,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic             rob_done,
  input  logic             stores_pending,
  input  logic             store_committed,
  input  logic [PC_W-1:0]  saved_pc,
  input  logic [PC_W-1:0]  saved_npc,
  output logic             bc_squash,
  output logic             bc_squashing,
  output logic [SEQ_W-1:0] bc_done_seq,
  output logic             bc_mis,
  output logic             bc_tak,
  output logic [PC_W-1:0]  bc_pc,
  output logic [PC_W-1:0]  bc_npc,
  output logic             rob_cmd,
  output logic [SEQ_W-1:0] rob_seq,
  output logic             empty_ind,
  output logic             trap_inflight
);
  thr_state_e       state_q;
  logic             trap_due, ctx_pend_q, arm_q;
  logic [SEQ_W-1:0] youngest_q;
  logic             trap_take, ctx_take, whole, ex_ok, accept, fire_empty;
  logic [SEQ_W-1:0] whole_pt, ex_pt, ex_rob;

  squash_trap_timer #(.TRAP_LAT(TRAP_LAT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (trap_req),
    .clear    (trap_take),
    .inflight (trap_inflight),
    .due      (trap_due)
  );

  always_comb begin
    trap_take  = trap_due;
    ctx_take   = ctx_pend_q && !trap_due;
    whole      = trap_take || ctx_take;
    whole_pt   = rob_empty ? '0 : rob_head_seq - 1'b1;
    ex_ok      = ex_valid && !trap_inflight && !whole && (ex_seq <= youngest_q);
    ex_pt      = ex_incl ? ex_seq - 1'b1 : ex_seq;
    ex_rob     = ex_pt + SEQ_W'(DELAY_SLOT && ex_mis && ex_keep);
    accept     = whole || ex_ok;
    fire_empty = arm_q && rob_empty && !stores_pending && !store_committed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= TH_RUN;
      ctx_pend_q  <= 1'b0;
      arm_q       <= 1'b1;
      youngest_q  <= '0;
      bc_squash   <= 1'b0;
      rob_cmd     <= 1'b0;
      empty_ind   <= 1'b0;
      bc_done_seq <= '0;
      rob_seq     <= '0;
      bc_mis      <= 1'b0;
      bc_tak      <= 1'b0;
      bc_pc       <= '0;
      bc_npc      <= '0;
    end else begin
      ctx_pend_q <= ctx_req || (ctx_pend_q && !ctx_take);
      bc_squash  <= accept;
      rob_cmd    <= accept;
      empty_ind  <= fire_empty;
      if (accept)          arm_q <= 1'b1;
      else if (fire_empty) arm_q <= 1'b0;
      if (accept)                              state_q <= TH_SQUASH;
      else if (state_q == TH_SQUASH && rob_done) state_q <= TH_RUN;
      if (whole) begin
        bc_done_seq <= whole_pt;
        rob_seq     <= whole_pt;
        bc_mis      <= 1'b0;
        bc_tak      <= 1'b0;
        bc_pc       <= saved_pc;
        bc_npc      <= saved_npc;
        youngest_q  <= '0;
      end else if (ex_ok) begin
        bc_done_seq <= ex_pt;
        rob_seq     <= ex_rob;
        bc_mis      <= ex_mis;
        bc_tak      <= ex_tak;
        bc_pc       <= ex_pc;
        bc_npc      <= ex_npc;
        youngest_q  <= ex_pt;
      end else if (alloc_valid) begin
        youngest_q  <= alloc_seq;
      end
    end
  end

  assign bc_squashing = (state_q == TH_SQUASH);

  AST_TRAP_STARTS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !trap_inflight |=> trap_inflight); // R1
  AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_due && ctx_pend_q |=> !trap_inflight && bc_squash); // R2
  AST_WHOLE_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_pend_q && !trap_due && rob_empty |=> bc_squash && bc_done_seq == '0); // R3
  AST_NO_EX_IN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid && trap_inflight && !trap_due && !ctx_pend_q |=> !bc_squash); // R4
  AST_SQUASHING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bc_squashing && !rob_done |=> bc_squashing); // R7
  AST_EMPTY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    empty_ind |-> $past(rob_empty && !stores_pending && !store_committed)); // R8

endmodule

// File: rtl/squash_arbiter.sv
module squash_arbiter #(
  parameter int NT         = 2,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int TRAP_LAT   = 4,
  parameter bit DELAY_SLOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NT-1:0]     trap_req,
  input  logic [NT-1:0]     ctx_sq_req,
  input  logic [NT-1:0]     ex_sq_valid,
  input  logic [NT*SEQ_W-1:0] ex_sq_seq,
  input  logic [NT-1:0]     ex_incl_self,
  input  logic [NT-1:0]     ex_mispred,
  input  logic [NT-1:0]     ex_taken,
  input  logic [NT-1:0]     ex_keep_slot,
  input  logic [NT*PC_W-1:0] ex_pc,
  input  logic [NT*PC_W-1:0] ex_npc,
  input  logic [NT-1:0]     alloc_valid,
  input  logic [NT*SEQ_W-1:0] alloc_seq,
  input  logic [NT-1:0]     rob_empty,
  input  logic [NT*SEQ_W-1:0] rob_head_seq,
  input  logic [NT-1:0]     rob_done_sq,
  input  logic              stores_pending,
  input  logic [NT-1:0]     store_committed,
  input  logic [NT*PC_W-1:0] saved_pc,
  input  logic [NT*PC_W-1:0] saved_npc,
  output logic [NT-1:0]     bc_squash,
  output logic [NT-1:0]     bc_squashing,
  output logic [NT*SEQ_W-1:0] bc_done_seq,
  output logic [NT-1:0]     bc_mispred,
  output logic [NT-1:0]     bc_taken,
  output logic [NT*PC_W-1:0] bc_pc,
  output logic [NT*PC_W-1:0] bc_npc,
  output logic [NT-1:0]     rob_sq_cmd,
  output logic [NT*SEQ_W-1:0] rob_sq_seq,
  output logic [NT-1:0]     empty_ind,
  output logic [NT-1:0]     trap_inflight
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    squash_thread_ctrl #(
      .SEQ_W(SEQ_W), .PC_W(PC_W), .TRAP_LAT(TRAP_LAT), .DELAY_SLOT(DELAY_SLOT)
    ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .trap_req        (trap_req[t]),
      .ctx_req         (ctx_sq_req[t]),
      .ex_valid        (ex_sq_valid[t]),
      .ex_seq          (ex_sq_seq[t*SEQ_W +: SEQ_W]),
      .ex_incl         (ex_incl_self[t]),
      .ex_mis          (ex_mispred[t]),
      .ex_tak          (ex_taken[t]),
      .ex_keep         (ex_keep_slot[t]),
      .ex_pc           (ex_pc[t*PC_W +: PC_W]),
      .ex_npc          (ex_npc[t*PC_W +: PC_W]),
      .alloc_valid     (alloc_valid[t]),
      .alloc_seq       (alloc_seq[t*SEQ_W +: SEQ_W]),
      .rob_empty       (rob_empty[t]),
      .rob_head_seq    (rob_head_seq[t*SEQ_W +: SEQ_W]),
      .rob_done        (rob_done_sq[t]),
      .stores_pending  (stores_pending),
      .store_committed (store_committed[t]),
      .saved_pc        (saved_pc[t*PC_W +: PC_W]),
      .saved_npc       (saved_npc[t*PC_W +: PC_W]),
      .bc_squash       (bc_squash[t]),
      .bc_squashing    (bc_squashing[t]),
      .bc_done_seq     (bc_done_seq[t*SEQ_W +: SEQ_W]),
      .bc_mis          (bc_mispred[t]),
      .bc_tak          (bc_taken[t]),
      .bc_pc           (bc_pc[t*PC_W +: PC_W]),
      .bc_npc          (bc_npc[t*PC_W +: PC_W]),
      .rob_cmd         (rob_sq_cmd[t]),
      .rob_seq         (rob_sq_seq[t*SEQ_W +: SEQ_W]),
      .empty_ind       (empty_ind[t]),
      .trap_inflight   (trap_inflight[t])
    );
  end

  AST_CMD_WITH_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    rob_sq_cmd == bc_squash); // R9

endmodule

// File: tb/squash_arbiter_bench.sv
module squash_arbiter_bench;
  localparam int NT = 2, SEQ_W = 16, PC_W = 32, TRAP_LAT = 4;

  typedef struct packed {
    logic             thr;
    logic [SEQ_W-1:0] done;
    logic [SEQ_W-1:0] rseq;
    logic             mis;
    logic             tak;
    logic [PC_W-1:0]  pc;
    logic [PC_W-1:0]  npc;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] trap_req = '0, ctx_sq_req = '0, ex_sq_valid = '0, ex_incl_self = '0;
  logic [NT-1:0] ex_mispred = '0, ex_taken = '0, ex_keep_slot = '0, alloc_valid = '0;
  logic [NT-1:0] rob_empty = '1, rob_done_sq = '0, store_committed = '0;
  logic stores_pending = 1'b1;
  logic [NT*SEQ_W-1:0] ex_sq_seq = '0, alloc_seq = '0, rob_head_seq = '0;
  logic [NT*PC_W-1:0] ex_pc = '0, ex_npc = '0;
  logic [NT*PC_W-1:0] saved_pc = {32'h0000_B000, 32'h0000_A000};
  logic [NT*PC_W-1:0] saved_npc = {32'h0000_B004, 32'h0000_A004};
  logic [NT-1:0] bc_squash, bc_squashing, bc_mispred, bc_taken, rob_sq_cmd, empty_ind, trap_inflight;
  logic [NT*SEQ_W-1:0] bc_done_seq, rob_sq_seq;
  logic [NT*PC_W-1:0] bc_pc, bc_npc;

  int n_chk = 0, n_err = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  squash_arbiter #(.NT(NT), .SEQ_W(SEQ_W), .PC_W(PC_W), .TRAP_LAT(TRAP_LAT), .DELAY_SLOT(1'b1))
  u_squash_arbiter (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input int t, input int done, input int rseq, input logic mis,
                      input logic tak, input logic [PC_W-1:0] pc, input logic [PC_W-1:0] npc);
    exp_t e;
    e.thr = t[0]; e.done = SEQ_W'(done); e.rseq = SEQ_W'(rseq);
    e.mis = mis; e.tak = tak; e.pc = pc; e.npc = npc;
    exp_q.push_back(e);
  endtask

  // Drive one execute-stage request; on return the result edge has passed.
  task automatic ex_sq(input int t, input int seq, input logic incl, input logic mis,
                       input logic tak, input logic keep, input logic [PC_W-1:0] pc,
                       input logic acc, input int done, input int rseq, input string req);
    ex_sq_valid[t] = 1'b1; ex_sq_seq[t*SEQ_W +: SEQ_W] = SEQ_W'(seq);
    ex_incl_self[t] = incl; ex_mispred[t] = mis; ex_taken[t] = tak; ex_keep_slot[t] = keep;
    ex_pc[t*PC_W +: PC_W] = pc; ex_npc[t*PC_W +: PC_W] = pc + 4;
    if (acc) push(t, done, rseq, mis, tak, pc, pc + 4);
    tick();
    ex_sq_valid[t] = 1'b0;
    check(req, 64'(bc_squash[t]), 64'(acc));
  endtask

  // Monitor: every broadcast squash pops one expected record.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < NT; t++) begin
        check("R9 cmd/pulse pairing", 64'(rob_sq_cmd[t]), 64'(bc_squash[t]));
        if (bc_squash[t]) begin
          if (exp_q.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R4 unexpected squash thread=%0d actual=1 expected=0", t);
          end else begin
            exp_t e;
            exp_t a;
            e = exp_q.pop_front();
            a.thr = t[0];
            a.done = bc_done_seq[t*SEQ_W +: SEQ_W];
            a.rseq = rob_sq_seq[t*SEQ_W +: SEQ_W];
            a.mis = bc_mispred[t]; a.tak = bc_taken[t];
            a.pc = bc_pc[t*PC_W +: PC_W]; a.npc = bc_npc[t*PC_W +: PC_W];
            n_chk++;
            if (a !== e) begin
              n_err++;
              $display("FAIL R3/R5/R6 record actual=%0h expected=%0h", a, e);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R9 reset squash", 64'(bc_squash), 0);
    check("R9 reset squashing", 64'(bc_squashing), 0);
    check("R9 reset inflight", 64'(trap_inflight), 0);
    rst_n = 1'b1;
    tick();
    check("R8 blocked by pending stores", 64'(empty_ind), 0);
    stores_pending = 1'b0;
    tick();
    check("R8 empty indication", 64'(empty_ind), 64'h3);
    tick();
    check("R9 empty pulse one cycle", 64'(empty_ind), 0);

    // Thread 0: execute-stage squashes.
    rob_empty[0] = 1'b0;
    alloc_valid[0] = 1'b1; alloc_seq[0 +: SEQ_W] = 16'd20;
    tick();
    alloc_valid[0] = 1'b0;
    ex_sq(0, 10, 0, 1, 1, 0, 32'h100, 1, 10, 10, "R5 accepted squash");
    check("R7 squashing set", 64'(bc_squashing[0]), 1);
    tick();
    check("R9 squash pulse cleared", 64'(bc_squash[0]), 0);
    check("R7 squashing held", 64'(bc_squashing[0]), 1);
    tick();
    check("R7 squashing held 2", 64'(bc_squashing[0]), 1);
    rob_done_sq[0] = 1'b1;
    tick();
    rob_done_sq[0] = 1'b0;
    check("R7 squashing released", 64'(bc_squashing[0]), 0);
    ex_sq(0, 12, 0, 0, 0, 0, 32'h200, 0, 0, 0, "R4 younger request rejected");
    ex_sq(0, 8, 1, 1, 0, 1, 32'h300, 1, 7, 8, "R6 include-self keep-slot");
    ex_sq(0, 7, 0, 0, 0, 1, 32'h400, 1, 7, 7, "R4 equal seq accepted");

    // Thread 1: trap with latency.
    rob_empty[1] = 1'b0; rob_head_seq[SEQ_W +: SEQ_W] = 16'd30;
    alloc_valid[1] = 1'b1; alloc_seq[SEQ_W +: SEQ_W] = 16'd50;
    tick();
    alloc_valid[1] = 1'b0;
    trap_req[1] = 1'b1;
    push(1, 29, 29, 0, 0, 32'h0000_B000, 32'h0000_B004);
    tick();
    trap_req[1] = 1'b0;
    check("R1 inflight raised", 64'(trap_inflight[1]), 1);
    tick();
    ex_sq(1, 5, 0, 0, 0, 0, 32'h500, 0, 0, 0, "R4 rejected during trap wait");
    tick();
    tick();
    check("R1 no early squash", 64'(bc_squash[1]), 0);
    check("R1 still inflight", 64'(trap_inflight[1]), 1);
    tick();
    check("R1 trap squash issued", 64'(bc_squash[1]), 1);
    check("R1 inflight cleared", 64'(trap_inflight[1]), 0);
    ex_sq(1, 1, 0, 0, 0, 0, 32'h600, 0, 0, 0, "R3 youngest reset rejects 1");
    ex_sq(1, 0, 0, 0, 0, 0, 32'h700, 1, 0, 0, "R3 youngest reset accepts 0");

    // Thread 0: trap and context-write due together.
    rob_empty[0] = 1'b1;
    trap_req[0] = 1'b1;
    push(0, 0, 0, 0, 0, 32'h0000_A000, 32'h0000_A004);
    tick();
    trap_req[0] = 1'b0;
    repeat (3) tick();
    ctx_sq_req[0] = 1'b1;
    push(0, 39, 39, 0, 0, 32'h0000_A000, 32'h0000_A004);
    tick();
    ctx_sq_req[0] = 1'b0;
    tick();
    check("R2 trap squash first", 64'(bc_squash[0]), 1);
    check("R2 trap cleared", 64'(trap_inflight[0]), 0);
    rob_empty[0] = 1'b0; rob_head_seq[0 +: SEQ_W] = 16'd40;
    tick();
    check("R2 context squash next", 64'(bc_squash[0]), 1);

    // Thread 1: empty indication blocked by a same-cycle store commit.
    store_committed[1] = 1'b1; rob_empty[1] = 1'b1;
    tick();
    check("R8 blocked by store commit", 64'(empty_ind[1]), 0);
    store_committed[1] = 1'b0;
    tick();
    check("R8 indication after store clear", 64'(empty_ind[1]), 1);
    tick();
    check("R3 all records seen", 64'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule